// File: doc/BRIEF.md
# Signed Field Insert Unit

This block places a bit field taken from the low end of a source operand at a chosen offset inside a result word. Result bits below the placed field are cleared. Result bits above it repeat the top bit of the field, so the field reads as a signed value scaled by a power of two. A size input selects 64-bit or 32-bit operation. In 32-bit operation only the lower half of the source is used, and the upper half of the result is zero.

Operands arrive in one of two forms, chosen by a form input. The direct form gives the field's position and length. The immediate-pair form gives a rotate amount and a top-bit index. The block converts the direct form into the pair before the shared datapath. In the pair form, a top index below the rotate amount selects insertion. A top index at or above the rotate amount selects a signed extract: the field is moved down to bit 0 and sign-extended.

The result is registered once. It appears exactly one cycle after a valid input, whatever the operand values.

Top module: `sbf_insert_unit`

## Requirements
- R1: In direct form (`in_form`=0) with a legal request, result bits [pos+len-1:pos] equal source bits [len-1:0].
- R2: In direct form with a legal request, every result bit below `pos` is 0.
- R3: In direct form with a legal request, every result bit from pos+len up to the operating size minus one equals source bit len-1.
- R4: When `in_wide`=0 (32-bit), source bits [63:32] have no effect and result bits [63:32] are 0. Legal positions are 0 to 31.
- R5: A direct-form request with len=0, pos at or above the size, or pos+len above the size gives `out_err`=1 and `out_data`=0. The size is 32 or 64.
- R6: In pair form (`in_form`=1), rot above top inserts source bits [top:0] at position size-rot, with the same zero and sign fill as R1 to R3.
- R7: In pair form, top at or above rot gives source bits [top:rot] at bit 0, with all higher bits (up to the size) equal to source bit top.
- R8: In pair form with `in_wide`=0, a rot or top value of 32 or more gives `out_err`=1 and `out_data`=0.
- R9: `out_valid` is `in_valid` delayed by exactly one clock, and each result belongs to the input accepted one clock earlier. The latency does not depend on the operand values.
- R10: While `rst_n` is low, `out_valid`, `out_data` and `out_err` are 0.
- R11: In a cycle after a clock edge where `in_valid` was 0, `out_data` and `out_err` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_wide | input | 1 | 1: 64-bit operation, 0: 32-bit operation |
| in_form | input | 1 | 0: direct position/length, 1: rotate/top pair |
| in_src | input | 64 | Source operand |
| in_pos | input | 6 | Direct form: field position |
| in_len | input | 7 | Direct form: field length (1 to size) |
| in_rot | input | 6 | Pair form: rotate amount |
| in_top | input | 6 | Pair form: top bit index of the source field |
| out_valid | output | 1 | Result present |
| out_data | output | 64 | Result word |
| out_err | output | 1 | Request was out of range; result forced to 0 |

## Verification
Almost all internal state is the single result register. A wrong shift amount, fill mask or sign bit therefore shows up in `out_data` on the very cycle after the request. A faulty range decode shows up at the same moment as an `out_err` that disagrees with the operands, or as a non-zero word beside the error flag. A slipped valid pipeline shows at once as a result with no request behind it, or a request with no result. The scoreboard pairs each request with the next valid output, so a one-cycle slip is caught. Boundary fields (length 1, position 0, field ending at the top bit) are included because mask and shift mistakes tend to appear only at those edges.

// File: rtl/sbf_pkg.sv
package sbf_pkg;

   typedef enum logic {
      FORM_DIRECT = 1'b0,
      FORM_PAIR   = 1'b1
   } sbf_form_e;

   typedef enum logic {
      SHIFT_OPERATOR = 1'b0,
      SHIFT_LOGSTAGE = 1'b1
   } sbf_shift_style_e;

endpackage

// File: rtl/sbf_barrel.sv
module sbf_barrel #(
   parameter int   W          = 64,
   parameter int   AMT_W      = $clog2(W),
   parameter bit   SHIFT_LEFT = 1'b1,
   parameter logic STYLE      = sbf_pkg::SHIFT_OPERATOR
) (
   input  logic [W-1:0]     din,
   input  logic [AMT_W-1:0] amt,
   output logic [W-1:0]     dout
);

   initial begin
      if (W < 2)
         $error("sbf_barrel: W must be at least 2");
      if ((1 << AMT_W) < W)
         $error("sbf_barrel: AMT_W too small for W");
   end

   generate
      if (STYLE == sbf_pkg::SHIFT_OPERATOR) begin : g_op
         if (SHIFT_LEFT) begin : g_l
            assign dout = din << amt;
         end else begin : g_r
            assign dout = din >> amt;
         end
      end else begin : g_stage
         logic [W-1:0] stg [0:AMT_W];
         assign stg[0] = din;
         for (genvar k = 0; k < AMT_W; k++) begin : g_k
            if (SHIFT_LEFT) begin : g_l
               assign stg[k+1] = amt[k] ? (stg[k] << (1 << k)) : stg[k];
            end else begin : g_r
               assign stg[k+1] = amt[k] ? (stg[k] >> (1 << k)) : stg[k];
            end
         end
         assign dout = stg[AMT_W];
      end
   endgenerate

endmodule

// File: rtl/sbf_operand_norm.sv
module sbf_operand_norm #(
   parameter int DATA_W   = 64,
   parameter int NARROW_W = 32,
   localparam int AMT_W   = $clog2(DATA_W)
) (
   input  logic             wide,
   input  logic             form,
   input  logic [AMT_W-1:0] pos,
   input  logic [AMT_W:0]   len,
   input  logic [AMT_W-1:0] rot,
   input  logic [AMT_W-1:0] top,
   output logic [AMT_W-1:0] immr,
   output logic [AMT_W-1:0] imms,
   output logic             err
);
   import sbf_pkg::*;

   localparam logic [AMT_W:0]   FULL_SZ   = (AMT_W+1)'(DATA_W);
   localparam logic [AMT_W:0]   HALF_SZ   = (AMT_W+1)'(NARROW_W);

   logic [AMT_W:0]   size_w;
   logic [AMT_W:0]   size_mask;
   logic [AMT_W+1:0] span;
   logic [AMT_W:0]   neg_pos;
   logic [AMT_W:0]   len_m1;
   logic             d_err;
   logic             p_err;
   logic [AMT_W-1:0] d_rot;
   logic [AMT_W-1:0] d_top;

   always_comb begin
      size_w    = wide ? FULL_SZ : HALF_SZ;
      size_mask = size_w - 1'b1;
      span      = {2'b00, pos} + {1'b0, len};
      d_err     = (len == '0)
               || ({1'b0, pos} >= size_w)
               || (span > {1'b0, size_w});
      neg_pos   = (size_w - {1'b0, pos}) & size_mask;
      len_m1    = len - 1'b1;
      d_rot     = neg_pos[AMT_W-1:0];
      d_top     = len_m1[AMT_W-1:0];
      p_err     = !wide && (({1'b0, rot} >= HALF_SZ) || ({1'b0, top} >= HALF_SZ));
   end

   always_comb begin
      if (sbf_form_e'(form) == FORM_DIRECT) begin
         immr = d_rot;
         imms = d_top;
         err  = d_err;
      end else begin
         immr = rot;
         imms = top;
         err  = p_err;
      end
   end

endmodule

// File: rtl/sbf_field_engine.sv
module sbf_field_engine #(
   parameter int   DATA_W      = 64,
   parameter int   NARROW_W    = 32,
   parameter logic SHIFT_STYLE = sbf_pkg::SHIFT_OPERATOR,
   localparam int  AMT_W       = $clog2(DATA_W)
) (
   input  logic              wide,
   input  logic [DATA_W-1:0] src,
   input  logic [AMT_W-1:0]  immr,
   input  logic [AMT_W-1:0]  imms,
   output logic [DATA_W-1:0] res
);

   localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
   localparam logic [DATA_W-1:0] HALF_MASK = {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
   localparam logic [AMT_W:0]    FULL_SZ   = (AMT_W+1)'(DATA_W);
   localparam logic [AMT_W:0]    HALF_SZ   = (AMT_W+1)'(NARROW_W);

   logic [DATA_W-1:0] size_mask;
   logic [DATA_W-1:0] src_m;
   logic              insert_mode;
   logic              sign_bit;
   logic [AMT_W:0]    ins_pos;
   logic [AMT_W:0]    top_idx;
   logic [AMT_W:0]    keep_amt;
   logic [DATA_W-1:0] keep_mask;
   logic [DATA_W-1:0] up_shifted;
   logic [DATA_W-1:0] dn_shifted;
   logic [DATA_W-1:0] moved;

   always_comb begin
      size_mask   = wide ? ALL_ONES : HALF_MASK;
      src_m       = src & size_mask;
      insert_mode = (imms < immr);
      sign_bit    = src_m[imms];
      ins_pos     = (wide ? FULL_SZ : HALF_SZ) - {1'b0, immr};
   end

   sbf_barrel #(
      .W          (DATA_W),
      .AMT_W      (AMT_W),
      .SHIFT_LEFT (1'b1),
      .STYLE      (SHIFT_STYLE)
   ) up_i (
      .din  (src_m),
      .amt  (ins_pos[AMT_W-1:0]),
      .dout (up_shifted)
   );

   sbf_barrel #(
      .W          (DATA_W),
      .AMT_W      (AMT_W),
      .SHIFT_LEFT (1'b0),
      .STYLE      (SHIFT_STYLE)
   ) dn_i (
      .din  (src_m),
      .amt  (immr),
      .dout (dn_shifted)
   );

   always_comb begin
      if (insert_mode) begin
         moved   = up_shifted;
         top_idx = ins_pos + {1'b0, imms};
      end else begin
         moved   = dn_shifted;
         top_idx = {1'b0, imms} - {1'b0, immr};
      end
      keep_amt  = top_idx + 1'b1;
      keep_mask = ~(ALL_ONES << keep_amt);
      res       = ((moved & keep_mask) | (sign_bit ? ~keep_mask : '0)) & size_mask;
   end

endmodule

// File: rtl/sbf_out_reg.sv
module sbf_out_reg #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] d_in,
   input  logic              e_in,
   output logic              v_q,
   output logic [DATA_W-1:0] d_q,
   output logic              e_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         d_q <= '0;
         e_q <= 1'b0;
      end else begin
         v_q <= cap;
         if (cap) begin
            d_q <= e_in ? '0 : d_in;
            e_q <= e_in;
         end
      end
   end

endmodule

// File: rtl/sbf_insert_unit.sv
module sbf_insert_unit #(
   parameter int   DATA_W      = 64,
   parameter int   NARROW_W    = 32,
   parameter logic SHIFT_STYLE = sbf_pkg::SHIFT_OPERATOR,
   localparam int  AMT_W       = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_wide,
   input  logic              in_form,
   input  logic [DATA_W-1:0] in_src,
   input  logic [AMT_W-1:0]  in_pos,
   input  logic [AMT_W:0]    in_len,
   input  logic [AMT_W-1:0]  in_rot,
   input  logic [AMT_W-1:0]  in_top,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_err
);

   initial begin
      if (DATA_W != 2 * NARROW_W)
         $error("sbf_insert_unit: DATA_W must be twice NARROW_W");
      if ((1 << AMT_W) != DATA_W)
         $error("sbf_insert_unit: DATA_W must be a power of two");
   end

   logic [AMT_W-1:0]  n_immr;
   logic [AMT_W-1:0]  n_imms;
   logic              n_err;
   logic [DATA_W-1:0] eng_res;

   sbf_operand_norm #(
      .DATA_W   (DATA_W),
      .NARROW_W (NARROW_W)
   ) norm_i (
      .wide (in_wide),
      .form (in_form),
      .pos  (in_pos),
      .len  (in_len),
      .rot  (in_rot),
      .top  (in_top),
      .immr (n_immr),
      .imms (n_imms),
      .err  (n_err)
   );

   sbf_field_engine #(
      .DATA_W      (DATA_W),
      .NARROW_W    (NARROW_W),
      .SHIFT_STYLE (SHIFT_STYLE)
   ) eng_i (
      .wide (in_wide),
      .src  (in_src),
      .immr (n_immr),
      .imms (n_imms),
      .res  (eng_res)
   );

   sbf_out_reg #(
      .DATA_W (DATA_W)
   ) oreg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (in_valid),
      .d_in  (eng_res),
      .e_in  (n_err),
      .v_q   (out_valid),
      .d_q   (out_data),
      .e_q   (out_err)
   );

endmodule

// File: rtl/sbf_insert_checks.sv
module sbf_insert_checks #(
   parameter int  DATA_W   = 64,
   parameter int  NARROW_W = 32,
   localparam int AMT_W    = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_wide,
   input logic              in_form,
   input logic [AMT_W-1:0]  in_pos,
   input logic [AMT_W:0]    in_len,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_err
);

   logic started;
   always_ff @(posedge clk) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (out_valid == $past(in_valid)));

   assert_err_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_data == '0));

   assert_len_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (started && in_valid && !in_form && (in_len == '0)) |=> out_err);

   assert_narrow_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(in_valid) && !$past(in_wide))
         |-> (out_data[DATA_W-1:NARROW_W] == '0));

   assert_low_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(in_valid) && !$past(in_form) && !out_err)
         |-> ((out_data & ~({DATA_W{1'b1}} << $past(in_pos))) == '0));

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (started && !$past(in_valid)) |-> ($stable(out_data) && $stable(out_err)));

endmodule

bind sbf_insert_unit sbf_insert_checks #(
   .DATA_W   (DATA_W),
   .NARROW_W (NARROW_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_wide   (in_wide),
   .in_form   (in_form),
   .in_pos    (in_pos),
   .in_len    (in_len),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_err   (out_err)
);

// File: tb/sbf_insert_unit_tb_top.sv
`timescale 1ns/1ps
module sbf_insert_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_wide = 1'b0;
   logic        in_form = 1'b0;
   logic [63:0] in_src = '0;
   logic [5:0]  in_pos = '0;
   logic [6:0]  in_len = '0;
   logic [5:0]  in_rot = '0;
   logic [5:0]  in_top = '0;
   logic        out_valid;
   logic [63:0] out_data;
   logic        out_err;

   always #2 clk = ~clk;

   sbf_insert_unit dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_wide   (in_wide),
      .in_form   (in_form),
      .in_src    (in_src),
      .in_pos    (in_pos),
      .in_len    (in_len),
      .in_rot    (in_rot),
      .in_top    (in_top),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_err   (out_err)
   );

   typedef struct {
      logic [63:0] d;
      bit          e;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_checks = 0;
   int          n_fail   = 0;
   bit          mon_en   = 1'b0;
   bit          finished = 1'b0;
   logic [63:0] last_d   = '0;
   bit          last_e   = 1'b0;

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
      end
   endtask

   function automatic void model(bit wide, bit form, logic [63:0] src,
                                 int pos, int len, int rot, int top,
                                 output logic [63:0] d, output bit e);
      int size;
      int lsb;
      int wdt;
      int base;
      bit ins;
      size = wide ? 64 : 32;
      d = '0; e = 1'b0; lsb = 0; wdt = 0; base = 0; ins = 1'b1;
      if (!form) begin
         if (len < 1 || pos >= size || pos + len > size) e = 1'b1;
         else begin lsb = pos; wdt = len; end
      end else begin
         if (rot >= size || top >= size) e = 1'b1;
         else if (top < rot) begin lsb = size - rot; wdt = top + 1; end
         else begin ins = 1'b0; base = rot; wdt = top - rot + 1; end
      end
      if (!e) begin
         for (int i = 0; i < size; i++) begin
            if (ins) begin
               if (i < lsb)            d[i] = 1'b0;
               else if (i < lsb + wdt) d[i] = src[i-lsb];
               else                    d[i] = src[wdt-1];
            end else begin
               if (i < wdt) d[i] = src[base+i];
               else         d[i] = src[top];
            end
         end
      end
   endfunction

   task automatic send(bit wide, bit form, logic [63:0] src, int pos, int len,
                       int rot, int top, string tag);
      exp_t x;
      @(negedge clk);
      in_valid = 1'b1;
      in_wide  = wide;
      in_form  = form;
      in_src   = src;
      in_pos   = 6'(pos);
      in_len   = 7'(len);
      in_rot   = 6'(rot);
      in_top   = 6'(top);
      model(wide, form, src, pos, len, rot, top, x.d, x.e);
      x.tag = tag;
      sb_q.push_back(x);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_src   = {$urandom, $urandom};
         in_pos   = 6'($urandom);
      end
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (mon_en) begin
            if (out_valid) begin
               if (sb_q.size() == 0) begin
                  check(1'b0, "R9 unexpected out_valid", 64'(out_valid), 64'd0);
               end else begin
                  exp_t x;
                  x = sb_q.pop_front();
                  check(out_data == x.d, {x.tag, " data"}, out_data, x.d);
                  check(out_err == x.e, {x.tag, " err"}, 64'(out_err), 64'(x.e));
                  last_d = out_data;
                  last_e = out_err;
               end
            end else begin
               check(out_data == last_d && out_err == last_e, "R11 hold",
                     out_data, last_d);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] s;
      in_valid = 1'b1;
      in_src   = '1;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0 && out_err == 1'b0,
            "R10 reset outputs", out_data, 64'd0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0 && out_err == 1'b0,
            "R10 after release", out_data, 64'd0);
      mon_en = 1'b1;

      // direct form, 64-bit
      send(1, 0, 64'h0123_4567_89AB_CDEF, 0, 1, 0, 0, "R1 pos0 len1");
      send(1, 0, 64'hFEDC_BA98_7654_3210, 0, 64, 0, 0, "R1 pos0 full");
      send(1, 0, 64'h0000_0000_0000_0001, 63, 1, 0, 0, "R2 top bit");
      send(1, 0, 64'h0000_0800_0000_0000, 20, 44, 0, 0, "R3 span to top");
      send(1, 0, 64'h1111_1111_1111_1180, 8, 8, 0, 0, "R3 sign one");
      send(1, 0, 64'hFFFF_FFFF_FFFF_FF7F, 8, 8, 0, 0, "R3 sign zero");
      idle(2);
      // 32-bit
      send(0, 0, 64'hDEAD_BEEF_8000_0001, 0, 32, 0, 0, "R4 full narrow");
      send(0, 0, 64'hFFFF_FFFF_0000_0001, 31, 1, 0, 0, "R4 top narrow");
      send(0, 0, 64'hAAAA_AAAA_0000_0ABC, 4, 12, 0, 0, "R4 sign narrow");
      send(0, 0, 64'h5555_5555_0000_07FF, 20, 12, 0, 0, "R4 end at 32");
      // range errors
      send(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 5, 0, 0, 0, "R5 len zero");
      send(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 60, 5, 0, 0, "R5 wide overrun");
      send(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 33, 1, 0, 0, "R5 narrow pos");
      send(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 20, 13, 0, 0, "R5 narrow overrun");
      send(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 65, 0, 0, "R5 len above size");
      idle(3);
      // pair form
      send(1, 1, 64'h0000_0000_0000_00C3, 0, 0, 56, 7, "R6 insert wide");
      send(0, 1, 64'hFFFF_FFFF_0000_0001, 0, 0, 1, 0, "R6 insert narrow");
      send(1, 1, 64'h0000_0000_0000_8765, 0, 0, 4, 11, "R7 extract wide");
      send(0, 1, 64'h1234_5678_9ABC_DEF0, 0, 0, 0, 31, "R7 extract narrow full");
      send(1, 1, 64'h8000_0000_0000_0000, 0, 0, 63, 63, "R7 rot eq top");
      send(0, 1, 64'h0000_0000_0000_FFFF, 0, 0, 33, 2, "R8 narrow rot");
      send(0, 1, 64'h0000_0000_0000_FFFF, 0, 0, 3, 40, "R8 narrow top");
      idle(2);

      // random, back to back with occasional gaps
      for (int k = 0; k < 400; k++) begin
         bit w;
         bit f;
         int sz;
         int p;
         int l;
         w  = 1'($urandom);
         f  = 1'($urandom);
         sz = w ? 64 : 32;
         s  = {$urandom, $urandom};
         p  = $urandom_range(sz - 1);
         l  = ($urandom_range(9) == 0) ? $urandom_range(64) : $urandom_range(sz - p, 1);
         if (f) send(w, f, s, 0, 0, $urandom_range(sz - 1), $urandom_range(sz - 1),
                     k[0] ? "R6 random pair" : "R7 random pair");
         else   send(w, f, s, p, l, 0, 0,
                     k[0] ? "R1 random direct" : "R3 random direct");
         if ($urandom_range(7) == 0) idle(1);
      end
      idle(4);
      check(sb_q.size() == 0, "R9 results drained", 64'(sb_q.size()), 64'd0);
      finished = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule